// File: doc/BRIEF.md
# Write-Load-Aware Die Allocator

This block chooses which flash die receives each incoming write in a storage controller whose dies run program operations independently of one another. It keeps, for every die, a busy/idle state and a lifetime total of pages written to it. A write request arrives with a page count over a valid/ready handshake. One cycle after acceptance the block presents the chosen die index as a single-cycle grant. In the same cycle the chosen die shows as busy and its total has grown by the page count. Each die reports the end of its operation with a one-cycle done pulse, which returns it to idle.

Idle dies are always preferred, so consecutive writes spread across the dies. When every die is busy, the request still gets a die: the one with the smallest lifetime total. Over a long run this keeps program wear even across the dies instead of following a fixed rotation. Lifetime totals only ever grow, and they stop at their all-ones value rather than wrapping.

Top module: `wl_die_alloc`

## Requirements
- R1: While `rst_n` is low, `req_ready` and `grant_valid` are 0, every die is idle and every total is zero. From the first rising edge after reset is released, `req_ready` is 1 and stays 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `grant_valid` is 1 for exactly the following cycle, together with the chosen die on `grant_die`. In any cycle that does not follow an acceptance, `grant_valid` is 0.
- R3: If at least one die is idle when a request is accepted, the chosen die is an idle one.
- R4: Among idle dies, the die with the smallest lifetime total is chosen. When totals are equal, the lowest die index wins.
- R5: If no die is idle, the busy die with the smallest lifetime total is chosen. When totals are equal, the lowest die index wins.
- R6: Each grant adds `req_pages` to the chosen die's lifetime total, and a page count of zero is allowed. No busy/idle change ever lowers a total.
- R7: A lifetime total that would pass 2^CNT_W-1 stays at 2^CNT_W-1.
- R8: The chosen die is busy from the cycle in which its grant is shown. A one-cycle pulse on bit i of `die_done` while die i is busy makes die i idle from the next cycle.
- R9: A pulse on `die_done` for a die that is already idle changes neither its state nor its total.
- R10: If a die is chosen on the same edge that its `die_done` bit is high, the die ends up busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_pages | input | LEN_W | Number of pages in the offered write |
| grant_valid | output | 1 | One-cycle grant for the request accepted on the previous edge |
| grant_die | output | IDX_W | Index of the die chosen for that request |
| die_done | input | NUM_DIES | Per-die completion pulse |

## Verification
The bench builds the block with four dies, six-bit lifetime totals and six-bit page counts. A four-die set is large enough to reach all of these cases: several idle dies with equal and unequal totals, every die busy, and completions on several dies in one cycle. Six-bit totals let a short run drive a die to the saturation value of 63 with one large write. The run then shows that the saturated die loses to dies whose totals lie between its wrapped value and the ceiling. A zero-page write on a die that is completing in the same cycle leaves that die the least loaded. This makes any wrong release of that die visible in the choice that follows.

// File: rtl/wlda_pkg.sv
package wlda_pkg;

  typedef enum logic {
    DIE_IDLE = 1'b0,
    DIE_BUSY = 1'b1
  } die_state_e;

endpackage

// File: rtl/wlda_die_slot.sv
module wlda_die_slot
  import wlda_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bind_en,
  input  logic [LEN_W-1:0] bind_pages,
  input  logic             done_pulse,
  output logic             busy,
  output logic [CNT_W-1:0] wr_total
);

  localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] CAP = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  die_state_e       state_q, state_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [SUM_W-1:0] sum;
  logic             state_en;
  logic             total_en;

  always_comb begin
    sum      = SUM_W'(total_q) + SUM_W'(bind_pages);
    state_d  = state_q;
    total_d  = total_q;
    state_en = bind_en | (done_pulse & (state_q == DIE_BUSY));
    total_en = bind_en;
    if (done_pulse && state_q == DIE_BUSY) state_d = DIE_IDLE;
    if (bind_en) begin
      state_d = DIE_BUSY;
      total_d = (sum > CAP) ? CAP[CNT_W-1:0] : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIE_IDLE;
      total_q <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (total_en) total_q <= total_d;
    end
  end

  assign busy     = (state_q == DIE_BUSY);
  assign wr_total = total_q;

endmodule

// File: rtl/wlda_pick.sv
module wlda_pick #(
  parameter int NUM_DIES = 8,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 3
) (
  input  logic [NUM_DIES-1:0]       busy_vec,
  input  logic [NUM_DIES*CNT_W-1:0] total_flat,
  output logic [IDX_W-1:0]          pick_idx
);

  localparam int KEY_W = CNT_W + 1;

  logic [KEY_W-1:0] best_key;
  logic [KEY_W-1:0] cand_key;
  logic [IDX_W-1:0] best_idx;

  // Busy sits above the total, so any idle die outranks every busy die.
  always_comb begin
    best_key = {busy_vec[0], total_flat[CNT_W-1:0]};
    best_idx = '0;
    cand_key = '0;
    for (int i = 1; i < NUM_DIES; i++) begin
      cand_key = {busy_vec[i], total_flat[i*CNT_W +: CNT_W]};
      if (cand_key < best_key) begin
        best_key = cand_key;
        best_idx = IDX_W'(i);
      end
    end
  end

  assign pick_idx = best_idx;

endmodule

// File: rtl/wl_die_alloc.sv
module wl_die_alloc #(
  parameter int NUM_DIES = 8,
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 8,
  parameter int IDX_W    = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LEN_W-1:0]    req_pages,
  output logic                grant_valid,
  output logic [IDX_W-1:0]    grant_die,
  input  logic [NUM_DIES-1:0] die_done
);

  logic                      ready_q;
  logic                      accept;
  logic [IDX_W-1:0]          pick_idx;
  logic [NUM_DIES-1:0]       busy_vec;
  logic [NUM_DIES*CNT_W-1:0] total_flat;
  logic                      gv_q, gv_d;
  logic [IDX_W-1:0]          gd_q;

  assign accept = req_valid & ready_q;

  wlda_pick #(
    .NUM_DIES(NUM_DIES),
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W)
  ) u_pick (
    .busy_vec  (busy_vec),
    .total_flat(total_flat),
    .pick_idx  (pick_idx)
  );

  for (genvar i = 0; i < NUM_DIES; i++) begin : g_slot
    logic bind_here;
    assign bind_here = accept && (pick_idx == IDX_W'(i));
    wlda_die_slot #(
      .CNT_W(CNT_W),
      .LEN_W(LEN_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .bind_en   (bind_here),
      .bind_pages(req_pages),
      .done_pulse(die_done[i]),
      .busy      (busy_vec[i]),
      .wr_total  (total_flat[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    gv_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      gv_q    <= 1'b0;
      gd_q    <= '0;
    end else begin
      ready_q <= 1'b1;
      gv_q    <= gv_d;
      if (accept) gd_q <= pick_idx;
    end
  end

  assign req_ready   = ready_q;
  assign grant_valid = gv_q;
  assign grant_die   = gd_q;

endmodule

// File: rtl/wl_die_alloc_chk.sv
module wl_die_alloc_chk #(
  parameter int NUM_DIES = 8,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      grant_valid,
  input logic [IDX_W-1:0]          grant_die,
  input logic [NUM_DIES-1:0]       die_done,
  input logic [NUM_DIES-1:0]       busy_vec,
  input logic [NUM_DIES*CNT_W-1:0] total_flat
);

  logic [CNT_W:0] prev_key [NUM_DIES];

  for (genvar j = 0; j < NUM_DIES; j++) begin : g_die
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_key[j] <= '0;
      else        prev_key[j] <= {busy_vec[j], total_flat[j*CNT_W +: CNT_W]};
    end

    // R4 R5
    min_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (prev_key[grant_die] <= prev_key[j]));

    // R4 R5
    low_index_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && (IDX_W'(j) < grant_die)) |-> (prev_key[grant_die] < prev_key[j]));

    // R6
    total_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      total_flat[j*CNT_W +: CNT_W] >= $past(total_flat[j*CNT_W +: CNT_W]));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_vec[j] && die_done[j]) |=>
        (!busy_vec[j] || (grant_valid && grant_die == IDX_W'(j))));
  end

  // R2
  grant_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> grant_valid);

  // R2
  no_spurious_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !grant_valid);

  // R8
  granted_die_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> busy_vec[grant_die]);

  // R1
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

endmodule

bind wl_die_alloc wl_die_alloc_chk #(
  .NUM_DIES(NUM_DIES),
  .CNT_W   (CNT_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .grant_valid(grant_valid),
  .grant_die  (grant_die),
  .die_done   (die_done),
  .busy_vec   (busy_vec),
  .total_flat (total_flat)
);

// File: tb/wl_die_alloc_test.sv
module wl_die_alloc_test;

  localparam int ND   = 4;
  localparam int CW   = 6;
  localparam int LW   = 6;
  localparam int IW   = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [LW-1:0] req_pages;
  logic          grant_valid;
  logic [IW-1:0] grant_die;
  logic [ND-1:0] die_done;

  int    errs   = 0;
  int    checks = 0;
  bit    ended  = 0;
  int    exp_q [$];
  string tag_q [$];
  bit    m_busy [ND];
  int    m_cnt  [ND];

  always #5 clk = ~clk;

  wl_die_alloc #(.NUM_DIES(ND), .CNT_W(CW), .LEN_W(LW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pages  (req_pages),
    .grant_valid(grant_valid),
    .grant_die  (grant_die),
    .die_done   (die_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model choice: idle before busy, then smaller total, then lower index.
  function automatic int model_pick();
    int b = 0;
    for (int i = 1; i < ND; i++) begin
      if ({m_busy[i], m_cnt[i]} < {m_busy[b], m_cnt[b]}) b = i;
    end
    return b;
  endfunction

  // Scoreboard monitor: runs at the falling edge, before the driver.
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (grant_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected grant", int'(grant_die), -1);
        end else begin
          automatic int    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(int'(grant_die) == e, t, int'(grant_die), e);
        end
      end else begin
        check(exp_q.size() == 0, "R2 grant timing", 0, 1);
      end
    end
  end

  task automatic cyc(input bit rv, input int pages, input logic [ND-1:0] dn, input string tag);
    int sel = -1;
    @(negedge clk);
    #1;
    req_valid = rv;
    req_pages = LW'(pages);
    die_done  = dn;
    if (rv) begin
      sel = model_pick();
      exp_q.push_back(sel);
      tag_q.push_back(tag);
    end
    for (int d = 0; d < ND; d++) begin
      if (dn[d] && !(rv && d == sel)) m_busy[d] = 1'b0;
    end
    if (rv) begin
      m_busy[sel] = 1'b1;
      m_cnt[sel]  = (m_cnt[sel] + pages > CMAX) ? CMAX : m_cnt[sel] + pages;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int pk;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_pages = '0;
    die_done  = '0;
    for (int i = 0; i < ND; i++) begin
      m_busy[i] = 1'b0;
      m_cnt[i]  = 0;
    end
    repeat (3) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
      check(grant_valid == 1'b0, "R1 grant in reset", int'(grant_valid), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // Equal totals, all idle: index order (R4).
    cyc(1, 5, '0, "R4 tie by index");
    cyc(1, 3, '0, "R4 tie by index");
    cyc(1, 7, '0, "R4 tie by index");
    cyc(1, 1, '0, "R4 tie by index");
    // All busy: lowest total (R5), then tie 3/3 to lower index.
    cyc(1, 2, '0, "R5 least loaded busy");
    cyc(1, 1, '0, "R5 tie by index");
    // Completion frees the heaviest die, which is still preferred (R3, R8).
    cyc(0, 0, 4'b0100, "R8");
    cyc(1, 4, '0, "R3 idle preferred");
    // Two idle dies with different totals (R4).
    cyc(0, 0, 4'b1001, "R8");
    cyc(1, 1, '0, "R4 least loaded idle");
    // Request and completion of another die in the same cycle.
    cyc(1, 2, 4'b0010, "R3 idle preferred");
    // Completion on an already idle die is ignored (R9).
    cyc(0, 0, 4'b0010, "R9");
    cyc(1, 1, '0, "R9 idle die unchanged");
    // Grant and completion on the same die: die stays busy (R10).
    pk = model_pick();
    cyc(1, 0, ND'(1 << pk), "R10 same-edge grant");
    cyc(0, 0, ~ND'(1 << pk), "R10");
    cyc(1, 3, '0, "R10 die kept busy");
    cyc(1, 2, '0, "R6 totals accumulate");
    // Saturation phase (R6, R7).
    cyc(0, 0, '1, "R8");
    cyc(1, 30, '0, "R6 heavy write");
    cyc(1, 30, '0, "R6 heavy write");
    cyc(1, 30, '0, "R6 heavy write");
    cyc(1, 30, '0, "R6 heavy write");
    cyc(1, 40, '0, "R5 least loaded busy");
    cyc(1, 1, '0, "R7 saturated total");
    cyc(1, 1, '0, "R7 saturated total");
    cyc(1, 1, '0, "R7 saturated total");
    cyc(0, 0, '0, "R2");
    cyc(0, 0, '0, "R2");
    @(negedge clk);
    check(exp_q.size() == 0, "R2 all grants seen", exp_q.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule